// File: doc/BRIEF.md
# Word-Select Register Store with Destructive Read and Broadcast Write

This block is a small register store organised the way a word-select (two-dimensional) storage plane works. Each word has its own read-select line and write-select line, and each bit position has one data line that every word shares. The requester chooses words by raising bits in select vectors instead of sending an encoded address. As a result, one request can clear several words or write the same pattern into several words at once.

Reading a word is destructive. The selected word is forced to zero in the same cycle, and the bits that were 1 before the clear come back as sensed data. A write only sets bits, so the requester should clear a word before writing it. The exception is the combined clear-then-write operation, which replaces the contents in one step. The block does not put data back after a read. The requester does that if it needs the data kept.

Each request finishes in one clock. Read results are registered and appear on the cycle after the request, together with a valid strobe.

Top module: `lsel_word_store`

## Requirements
- R1: After synchronous reset, every stored bit is 0 and `sense_valid`, `sel_error` and `sense_data` are 0.
- R2: A request with `op` = 0 (read) and exactly one bit set in `rd_sel` gives `sense_valid` = 1 on the next cycle. `sense_data` then holds the selected word's contents from before the request. While `sense_valid` is 0, `sense_data` is 0.
- R3: A valid read leaves the selected word at 0, so an immediate second read of that word returns 0.
- R4: A read whose `rd_sel` has zero bits set, or more than one, gives `sel_error` = 1 for one cycle on the next cycle with `sense_valid` = 0. It changes no stored bit. `sel_error` and `sense_valid` are never high together.
- R5: `op` = 1 (clear) sets every word selected in `rd_sel` to 0. `bit_data` is ignored, and no sensed data or error is reported.
- R6: `op` = 2 (write) sets to 1 each bit that is 1 in `bit_data`, in every word selected in `wr_sel`. Bits that are already 1 stay 1.
- R7: When `wr_sel` has several bits set, a write places the same `bit_data` pattern into all the selected words in the same cycle.
- R8: `op` = 3 (clear-then-write) replaces every word selected in `wr_sel` with exactly `bit_data`.
- R9: When `req` is 0, nothing is stored or cleared, and on the next cycle `sense_valid` and `sel_error` are 0.
- R10: Write operations (codes 2 and 3) ignore `rd_sel`. Operations other than read never raise `sense_valid` or `sel_error`.
- R11: Words that are not selected by an operation keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request qualifier for the current cycle |
| op | input | 2 | Operation: 0 read, 1 clear, 2 write, 3 clear-then-write |
| rd_sel | input | NWORDS | Read-select lines, one per word |
| wr_sel | input | NWORDS | Write-select lines, one per word |
| bit_data | input | WIDTH | Shared bit data lines |
| sense_valid | output | 1 | Registered strobe for a valid read |
| sense_data | output | WIDTH | Registered sensed bits |
| sel_error | output | 1 | Registered flag for a malformed read select |

## Verification
Stored contents can only be seen through destructive reads. A wrong internal bit, such as a missed clear, a stray set or a row touched that should not have been, therefore shows up on `sense_data` one cycle after the next read of that word, and not before. The bench reads every word a sequence touched, and also its neighbours, so that broadcast and clear mistakes surface on the cycle after those reads. Errors in select decoding show up in `sense_valid` and `sel_error` one cycle after the offending request.

// File: rtl/lsel_pkg.sv
package lsel_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_CLEAR = 2'd1,
    OP_WRITE = 2'd2,
    OP_CLRWR = 2'd3
  } lsel_op_e;
endpackage

// File: rtl/lsel_sel_check.sv
// Flags a select vector that has exactly one bit set.
module lsel_sel_check #(
  parameter int NWORDS = 16
) (
  input  logic [NWORDS-1:0] sel,
  output logic              exactly_one
);
  localparam int CW = $clog2(NWORDS + 1);
  logic [CW-1:0] cnt;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < NWORDS; i++) begin
      cnt = cnt + CW'(sel[i]);
    end
    exactly_one = (cnt == CW'(1));
  end
endmodule

// File: rtl/lsel_word_row.sv
// One stored word: a clear strobe forces zero, a set strobe ORs in data.
module lsel_word_row #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             set,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] row
);
  always_ff @(posedge clk) begin
    if (rst) begin
      row <= '0;
    end else if (clr || set) begin
      row <= (clr ? '0 : row) | (set ? din : '0);
    end
  end
endmodule

// File: rtl/lsel_sense_or.sv
// Shared bit lines: each bit reports the OR over the selected words.
module lsel_sense_or #(
  parameter int NWORDS = 16,
  parameter int WIDTH  = 16
) (
  input  logic [NWORDS*WIDTH-1:0] rows_flat,
  input  logic [NWORDS-1:0]       sel,
  output logic [WIDTH-1:0]        lines
);
  always_comb begin
    lines = '0;
    for (int i = 0; i < NWORDS; i++) begin
      if (sel[i]) lines = lines | rows_flat[i*WIDTH +: WIDTH];
    end
  end
endmodule

// File: rtl/lsel_word_store.sv
module lsel_word_store
  import lsel_pkg::*;
#(
  parameter int NWORDS = 16,
  parameter int WIDTH  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [1:0]        op,
  input  logic [NWORDS-1:0] rd_sel,
  input  logic [NWORDS-1:0] wr_sel,
  input  logic [WIDTH-1:0]  bit_data,
  output logic              sense_valid,
  output logic [WIDTH-1:0]  sense_data,
  output logic              sel_error
);
  localparam int FLATW = NWORDS * WIDTH;

  lsel_op_e          op_e;
  logic              one_hot;
  logic              is_read;
  logic              read_ok;
  logic [NWORDS-1:0] clr_w;
  logic [NWORDS-1:0] set_w;
  logic [FLATW-1:0]  rows_flat;
  logic [WIDTH-1:0]  lines;

  assign op_e    = lsel_op_e'(op);
  assign is_read = req && (op_e == OP_READ);
  assign read_ok = is_read && one_hot;

  lsel_sel_check #(.NWORDS(NWORDS)) u_selchk (
    .sel         (rd_sel),
    .exactly_one (one_hot)
  );

  for (genvar i = 0; i < NWORDS; i++) begin : g_word
    assign clr_w[i] = req && (((op_e == OP_CLEAR) && rd_sel[i]) ||
                              (read_ok && rd_sel[i]) ||
                              ((op_e == OP_CLRWR) && wr_sel[i]));
    assign set_w[i] = req && ((op_e == OP_WRITE) || (op_e == OP_CLRWR)) && wr_sel[i];

    lsel_word_row #(.WIDTH(WIDTH)) u_row (
      .clk (clk),
      .rst (rst),
      .clr (clr_w[i]),
      .set (set_w[i]),
      .din (bit_data),
      .row (rows_flat[i*WIDTH +: WIDTH])
    );
  end

  lsel_sense_or #(.NWORDS(NWORDS), .WIDTH(WIDTH)) u_sense (
    .rows_flat (rows_flat),
    .sel       (rd_sel),
    .lines     (lines)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sense_valid <= 1'b0;
      sel_error   <= 1'b0;
      sense_data  <= '0;
    end else begin
      sense_valid <= read_ok;
      sel_error   <= is_read && !one_hot;
      sense_data  <= read_ok ? lines : '0;
    end
  end
endmodule

// File: rtl/lsel_word_store_chk.sv
module lsel_word_store_chk #(
  parameter int NWORDS = 16,
  parameter int WIDTH  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              req,
  input logic [1:0]        op,
  input logic [NWORDS-1:0] rd_sel,
  input logic              sense_valid,
  input logic [WIDTH-1:0]  sense_data,
  input logic              sel_error
);
  assert_excl_R4: assert property (@(posedge clk) disable iff (rst)
    !(sense_valid && sel_error));

  assert_bad_sel_R4: assert property (@(posedge clk) disable iff (rst)
    (req && op == 2'd0 && $countones(rd_sel) != 1) |=> (sel_error && !sense_valid));

  assert_good_sel_R2: assert property (@(posedge clk) disable iff (rst)
    (req && op == 2'd0 && $countones(rd_sel) == 1) |=> sense_valid);

  assert_quiet_data_R2: assert property (@(posedge clk) disable iff (rst)
    !sense_valid |-> (sense_data == '0));

  assert_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !req |=> (!sense_valid && !sel_error));

  assert_nonread_R10: assert property (@(posedge clk) disable iff (rst)
    (req && op != 2'd0) |=> (!sense_valid && !sel_error));
endmodule

bind lsel_word_store lsel_word_store_chk #(.NWORDS(NWORDS), .WIDTH(WIDTH)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req         (req),
  .op          (op),
  .rd_sel      (rd_sel),
  .sense_valid (sense_valid),
  .sense_data  (sense_data),
  .sel_error   (sel_error)
);

// File: tb/lsel_word_store_tb.sv
module lsel_word_store_tb;
  localparam int CLK_P = 10;
  localparam int N = 16;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req = 1'b0;
  logic [1:0]   op = 2'd0;
  logic [N-1:0] rd_sel = '0;
  logic [N-1:0] wr_sel = '0;
  logic [W-1:0] bit_data = '0;
  logic         sense_valid;
  logic [W-1:0] sense_data;
  logic         sel_error;

  logic [W-1:0] model [N];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  lsel_word_store #(.NWORDS(N), .WIDTH(W)) u_dut (
    .clk (clk), .rst (rst), .req (req), .op (op),
    .rd_sel (rd_sel), .wr_sel (wr_sel), .bit_data (bit_data),
    .sense_valid (sense_valid), .sense_data (sense_data), .sel_error (sel_error)
  );

  task automatic check(string tag, logic ev, logic [W-1:0] ed, logic ee);
    checks++;
    if (sense_valid !== ev || sense_data !== ed || sel_error !== ee) begin
      fails++;
      $display("FAIL %s: got v=%0b d=%h e=%0b, expected v=%0b d=%h e=%0b",
               tag, sense_valid, sense_data, sel_error, ev, ed, ee);
    end
  endtask

  // Drive one request at a falling edge, update the model, check one cycle later.
  task automatic apply(string tag, logic rq, logic [1:0] o, logic [N-1:0] rs,
                       logic [N-1:0] ws, logic [W-1:0] d);
    logic         ev = 1'b0;
    logic         ee = 1'b0;
    logic [W-1:0] ed = '0;
    req = rq; op = o; rd_sel = rs; wr_sel = ws; bit_data = d;
    if (rq) begin
      case (o)
        2'd0: if ($countones(rs) == 1) begin
          for (int i = 0; i < N; i++) if (rs[i]) begin ed = model[i]; model[i] = '0; end
          ev = 1'b1;
        end else ee = 1'b1;
        2'd1: for (int i = 0; i < N; i++) if (rs[i]) model[i] = '0;
        2'd2: for (int i = 0; i < N; i++) if (ws[i]) model[i] = model[i] | d;
        default: for (int i = 0; i < N; i++) if (ws[i]) model[i] = d;
      endcase
    end
    @(negedge clk);
    check(tag, ev, ed, ee);
  endtask

  task automatic rd(string tag, int w);
    apply(tag, 1'b1, 2'd0, N'(1) << w, '0, '0);
  endtask

  task automatic wr(string tag, logic [N-1:0] ws, logic [W-1:0] d);
    apply(tag, 1'b1, 2'd2, '0, ws, d);
  endtask

  initial begin
    for (int i = 0; i < N; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset outputs", 1'b0, '0, 1'b0);
    rd("R1 word after reset", 3);
    rd("R1 word after reset", 15);

    wr("R6 single write", N'(1) << 2, 16'hA5A5);
    rd("R2 read back", 2);
    rd("R3 second read zero", 2);

    wr("R7 broadcast", 16'h00F0, 16'h1234);
    for (int i = 3; i <= 8; i++) rd("R7 broadcast rows", i);

    wr("R6 first set", N'(1) << 1, 16'h00F0);
    wr("R6 accumulate", N'(1) << 1, 16'h0F00);
    rd("R6 or result", 1);

    wr("R11 prefill", 16'h0700, 16'hFFFF);
    apply("R5 clear two", 1'b1, 2'd1, 16'h0300, '0, 16'hFFFF);
    rd("R5 cleared", 8);
    rd("R5 cleared", 9);
    rd("R11 untouched", 10);

    wr("R4 prefill", N'(1) << 0, 16'hBEEF);
    apply("R4 multi select", 1'b1, 2'd0, 16'h0003, '0, '0);
    apply("R4 empty select", 1'b1, 2'd0, 16'h0000, '0, '0);
    rd("R4 unchanged", 0);

    wr("R8 prefill", N'(1) << 12, 16'hFFFF);
    apply("R8 clear-then-write", 1'b1, 2'd3, '0, 16'h3000, 16'h0F0F);
    rd("R8 replaced", 12);
    rd("R8 replaced", 13);

    apply("R9 idle write", 1'b0, 2'd2, '0, N'(1) << 14, 16'hFFFF);
    apply("R9 idle read", 1'b0, 2'd0, N'(1) << 14, '0, '0);
    rd("R9 no store", 14);

    wr("R10 prefill", N'(1) << 15, 16'h00FF);
    apply("R10 write ignores rd_sel", 1'b1, 2'd2, N'(1) << 15, '0, 16'h0000);
    apply("R10 clrwr ignores rd_sel", 1'b1, 2'd3, N'(1) << 15, N'(1) << 11, 16'h0042);
    rd("R10 kept", 15);
    rd("R8 via R10 row", 11);

    apply("R9 final idle", 1'b0, 2'd0, '0, '0, '0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule